// File: doc/BRIEF.md
# Compare Output Pin Control Unit

This block holds the one-bit output-compare state of a timer channel and decides what reaches the associated general-purpose I/O pin. A compare-match strobe from the counter/comparator, or a software force strobe, updates the state according to a two-bit compare action field. The action is hold, toggle, clear or set. A flag selects between the PWM and non-PWM families of waveform modes. Force strobes only act in the non-PWM family.

Whenever the action field is non-zero, the block replaces the port data bit with the compare state on the pin data path. Pin direction always stays with the separate direction bit. Software can therefore preset the compare state while the pin is still an input, and the pin shows that value as soon as its direction is switched to output. The counter, the comparator and any input-capture logic sit outside this block.

Top module: `cmp_pin_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the compare state to 0 on the clock edge where reset is sampled high.
- R2: With action field 2'b00, neither a match strobe nor a force strobe changes the compare state, in either waveform family.
- R3: On a match strobe, action 2'b01 inverts the state, 2'b10 drives it to 0 and 2'b11 drives it to 1. The new value appears on cmp_state_o right after the clock edge that samples the strobe.
- R4: With pwm_i low, a force strobe applies the same action as a match. A match and a force in the same cycle apply the action once (a single toggle).
- R5: With pwm_i high, a force strobe leaves the state unchanged, while match strobes still apply the set, clear and toggle encoding of R3.
- R6: pin_o equals the compare state whenever the action field is non-zero, and equals port_data_i when the field is 2'b00. It follows these without any register delay.
- R7: pin_oe_o equals dir_i at all times, independent of the action field and the strobes.
- R8: A state preset by a strobe while dir_i is low is visible on pin_o with pin_oe_o high in the same cycle that dir_i rises, with no further strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | 1 | Compare-match strobe, one cycle per event |
| force_i | input | 1 | Software force strobe |
| mode_i | input | 2 | Compare action: 00 hold, 01 toggle, 10 clear, 11 set |
| pwm_i | input | 1 | High when a PWM waveform mode is active |
| port_data_i | input | 1 | Normal port data bit |
| dir_i | input | 1 | Direction bit, 1 means output |
| pin_o | output | 1 | Value driven onto the pin |
| pin_oe_o | output | 1 | Pin output enable |
| cmp_state_o | output | 1 | Internal compare state |

## Verification
The assertions assume that every input is synchronous to clk and that a strobe lasts a single cycle. They also assume the action field and the PWM flag are valid in the cycle of the strobe. A strobe held high for several cycles is therefore read as several separate events. The bench drives all inputs just after the falling edge and changes them at most once per cycle. Directed phases cover each action, the force/PWM interplay and the preset sequence. A long pseudo-random phase follows, where every input may change in any cycle, and a behavioural model predicts all three outputs every cycle.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;
endpackage

// File: rtl/cmp_action.sv
module cmp_action
  import cmp_pkg::*;
(
  input  logic             cur_i,
  input  logic             match_i,
  input  logic             force_i,
  input  logic             pwm_i,
  input  logic [ACT_W-1:0] mode_i,
  output logic             nxt_o,
  output logic             upd_o
);
  logic evt;
  assign evt = match_i | (force_i & ~pwm_i);

  always_comb begin
    nxt_o = cur_i;
    unique case (cmp_act_e'(mode_i))
      ACT_HOLD:   nxt_o = cur_i;
      ACT_TOGGLE: nxt_o = ~cur_i;
      ACT_CLEAR:  nxt_o = 1'b0;
      ACT_SET:    nxt_o = 1'b1;
      default:    nxt_o = cur_i;
    endcase
  end

  assign upd_o = evt & (mode_i != ACT_HOLD);
endmodule

// File: rtl/cmp_state_reg.sv
module cmp_state_reg #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_i,
  input  logic nxt_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (upd_i) q_o <= nxt_i;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q_o == RST_VAL));
  a_r2_no_update_holds: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(q_o));
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
  import cmp_pkg::*;
(
  input  logic             state_i,
  input  logic [ACT_W-1:0] mode_i,
  input  logic             port_data_i,
  input  logic             dir_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  logic ovr;
  assign ovr      = |mode_i;
  assign pin_o    = ovr ? state_i : port_data_i;
  assign pin_oe_o = dir_i;
endmodule

// File: rtl/cmp_pin_ctrl.sv
module cmp_pin_ctrl
  import cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       match_i,
  input  logic       force_i,
  input  logic [1:0] mode_i,
  input  logic       pwm_i,
  input  logic       port_data_i,
  input  logic       dir_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       cmp_state_o
);
  logic nxt, upd, state;

  cmp_action u_act (
    .cur_i   (state),
    .match_i (match_i),
    .force_i (force_i),
    .pwm_i   (pwm_i),
    .mode_i  (mode_i),
    .nxt_o   (nxt),
    .upd_o   (upd)
  );

  cmp_state_reg #(.RST_VAL(1'b0)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .upd_i (upd),
    .nxt_i (nxt),
    .q_o   (state)
  );

  cmp_pin_mux u_mux (
    .state_i     (state),
    .mode_i      (mode_i),
    .port_data_i (port_data_i),
    .dir_i       (dir_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o)
  );

  assign cmp_state_o = state;

  a_r2_mode0_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |=> $stable(cmp_state_o));
  a_r3_match_toggle: assert property (@(posedge clk) disable iff (rst)
    (match_i && mode_i == 2'b01) |=> (cmp_state_o != $past(cmp_state_o)));
  a_r3_match_clear: assert property (@(posedge clk) disable iff (rst)
    (match_i && mode_i == 2'b10) |=> !cmp_state_o);
  a_r3_match_set: assert property (@(posedge clk) disable iff (rst)
    (match_i && mode_i == 2'b11) |=> cmp_state_o);
  a_r4_force_set: assert property (@(posedge clk) disable iff (rst)
    (force_i && !pwm_i && mode_i == 2'b11) |=> cmp_state_o);
  a_r5_force_ignored_pwm: assert property (@(posedge clk) disable iff (rst)
    (!match_i && pwm_i) |=> $stable(cmp_state_o));
  a_r6_pin_override: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b00) |-> (pin_o == cmp_state_o));
  a_r6_pin_port: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |-> (pin_o == port_data_i));
  a_r7_oe_dir: assert property (@(posedge clk) disable iff (rst)
    pin_oe_o == dir_i);
endmodule

// File: tb/cmp_pin_ctrl_tb.sv
module cmp_pin_ctrl_tb;
  logic clk = 1'b0;
  logic rst, match_i, force_i, pwm_i, port_data_i, dir_i;
  logic [1:0] mode_i;
  logic pin_o, pin_oe_o, cmp_state_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_st  = 0;   // reference model state

  always #2 clk = ~clk;  // 250 MHz

  cmp_pin_ctrl u_dut (
    .clk(clk), .rst(rst), .match_i(match_i), .force_i(force_i),
    .mode_i(mode_i), .pwm_i(pwm_i), .port_data_i(port_data_i),
    .dir_i(dir_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .cmp_state_o(cmp_state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after negedge, advance model at posedge, compare after it.
  task automatic step(input bit r, input bit m, input bit f, input int md,
                      input bit p, input bit pd, input bit d);
    string tag;
    int ev;
    @(negedge clk);
    rst = r; match_i = m; force_i = f; mode_i = md[1:0];
    pwm_i = p; port_data_i = pd; dir_i = d;
    @(posedge clk);
    ev = (m || (f && !p)) ? 1 : 0;
    if (r) begin m_st = 0; tag = "R1"; end
    else if (md == 0) tag = "R2";
    else if (f && !m) tag = p ? "R5" : "R4";
    else tag = "R3";
    if (!r && ev == 1) begin
      if (md == 1) m_st = 1 - m_st;
      else if (md == 2) m_st = 0;
      else if (md == 3) m_st = 1;
    end
    #1;
    chk(tag, int'(cmp_state_o), m_st);
    chk("R6", int'(pin_o), (md != 0) ? m_st : int'(pd));
    chk("R7", int'(pin_oe_o), int'(d));
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; match_i = 0; force_i = 0; mode_i = 0; pwm_i = 0;
    port_data_i = 0; dir_i = 0;
    // R1: reset
    step(1, 0, 0, 0, 0, 1, 1);
    step(1, 1, 0, 3, 0, 1, 1);
    // R3: match actions in non-PWM family
    step(0, 1, 0, 3, 0, 0, 1);
    step(0, 1, 0, 1, 0, 0, 1);
    step(0, 1, 0, 1, 0, 0, 1);
    step(0, 1, 0, 2, 0, 1, 1);
    // R2: hold with mode 00, pin shows port data
    step(0, 1, 1, 0, 0, 1, 1);
    step(0, 1, 0, 0, 1, 0, 1);
    // R4: force acts, match+force single toggle
    step(0, 0, 1, 3, 0, 0, 1);
    step(0, 1, 1, 1, 0, 0, 1);
    step(0, 0, 1, 1, 0, 0, 1);
    // R5: force ignored in PWM, match still acts
    step(0, 0, 1, 1, 1, 0, 1);
    step(0, 0, 1, 3, 1, 0, 1);
    step(0, 1, 0, 3, 1, 0, 1);
    step(0, 1, 0, 2, 1, 0, 1);
    step(0, 1, 0, 1, 1, 0, 1);
    // R8: preset while input, then enable output
    step(0, 0, 1, 2, 0, 1, 0);
    step(0, 0, 1, 3, 0, 0, 0);
    step(0, 0, 0, 3, 0, 0, 0);
    step(0, 0, 0, 3, 0, 0, 1);
    chk("R8", int'(pin_o), 1);
    chk("R8", int'(pin_oe_o), 1);
    // R7: oe tracks dir under all modes
    step(0, 1, 0, 1, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    // Pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      int rv;
      rv = $urandom;
      step((rv % 97) == 0, rv[4], rv[5], rv[7:6], rv[8], rv[9], rv[10]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule